// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer with a parameterised number of 32-bit channels. Each channel has three registers: a control word, an interval, and a current count that software can only read. Two registers serve every channel: an interrupt-enable mask and an expiry status word. Software clears a status bit by writing a 1 to it. One interrupt line combines all channels.

Each channel counts down on its own tick. The control word selects the tick source: the core clock, or one of three external strobes. A prescaler then divides that source by a power of two. In periodic mode a channel reloads from its interval after it expires. In one-shot mode it halts. A channel with an all-ones interval in periodic mode wraps for ever, so software can invert its count and use it as a free-running up-counter.

A disable does not take effect at once. The channel applies a fixed number of further ticks before it halts. Software must therefore wait a few reference ticks before it reprograms a channel it has just disabled.

Top module: `mtmr_top`

## Requirements
- R1: After a synchronous reset, every register reads 0, all channels are halted, and `irq_o` is low.
- R2: Register map:
  - interrupt-enable at 0x00, with bit n for channel n.
  - expiry status at 0x04.
  - for channel n: control at 0x10·n+0x10, interval at 0x10·n+0x14, and count at 0x10·n+0x18.
  - The count register ignores writes. Unmapped addresses read 0.
- R3: Control word bits:
  - bit 0 is enable.
  - bit 1 is reload.
  - bits 3:2 select the source.
  - bits 6:4 are the prescaler exponent.
  - bit 7 selects one-shot mode.
  - The word reads back as written, except that reload clears itself once the load has been done.
- R4: A control write with both enable and reload set starts the channel. Its next tick copies the interval into the count, with no decrement on that tick. Each later tick decrements the count by one.
- R5: In periodic mode (bit 7 = 0), a tick that finds the count at 0 sets the channel's status bit and reloads the count from the interval.
- R6: In one-shot mode (bit 7 = 1), a tick that finds the count at 0 sets the status bit, halts the channel and clears its enable bit. The count then stays at 0.
- R7: Source select 0 gives one tick per core clock cycle. Source select s = 1 to 3 takes each cycle in which `ext_tick[s-1]` is high as one source strobe.
- R8: With prescaler exponent p, the channel ticks once every 2^p source strobes. Strobes are counted from the write that starts a halted channel.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: An expiry sets the status bit whether or not the channel's interrupt is enabled. `irq_o` is high exactly when some channel has both its status bit and its enable bit set.
- R11: A control write that clears enable on a running channel reads back with enable 0 at once. The channel still applies exactly two more ticks, then halts with its count frozen.
- R12: A periodic channel with interval 0xFFFFFFFF wraps its count from 0 to 0xFFFFFFFF and keeps running.
- R13: Setting enable without reload on a running channel continues counting from the current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_tick | input | 3 | External tick strobes for source selects 1 to 3 |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Channel 0 runs from a strobe that the bench pulses one at a time. This lets each test tell the load tick apart from a decrement, a periodic reload apart from a one-shot halt, and a divide-by-four prescaler apart from no division. Two tests switch a running channel to a new control word: one keeps enable set and one clears it. Together they separate resuming from the current count from the two-tick delayed halt, and the strobes after the halt show that the count is frozen. Channel 1 runs from the core clock. Reads taken a fixed number of cycles apart confirm one tick per clock. Swapping the interval under a loaded count drives a count of 0 through an all-ones reload, which exercises the wrap.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_SRC    = 4;
    localparam int PRE_W      = 3;
    localparam int PDIV_W     = (1 << PRE_W) - 1;

    localparam logic [7:0] OFS_IEN  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;

    // field positions are fixed by software: bit0 en, bit1 rld, [3:2] src, [6:4] pre, bit7 one
    typedef struct packed {
        logic             one;
        logic [PRE_W-1:0] pre;
        logic [1:0]       src;
        logic             rld;
        logic             en;
    } mtmr_ctrl_t;

    typedef enum logic [1:0] {
        SUB_CTRL = 2'd0,
        SUB_INTV = 2'd1,
        SUB_CNT  = 2'd2,
        SUB_NONE = 2'd3
    } mtmr_sub_e;

    function automatic logic [WORD_W-1:0] ctrl_word(input mtmr_ctrl_t c);
        return {{(WORD_W-8){1'b0}}, c};
    endfunction

    function automatic logic [PDIV_W-1:0] pre_mask(input logic [PRE_W-1:0] p);
        logic [PDIV_W:0] full;
        full = ({{PDIV_W{1'b0}}, 1'b1} << p) - 1'b1;
        return full[PDIV_W-1:0];
    endfunction

endpackage

// File: rtl/mtmr_regif.sv
module mtmr_regif
    import mtmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    output logic                           wr_ien,
    output logic                           wr_stat,
    output logic [NUM_CH-1:0]              wr_ctrl,
    output logic [NUM_CH-1:0]              wr_intv,
    input  logic [NUM_CH-1:0]              ien_q,
    input  logic [NUM_CH-1:0]              stat_q,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  ctrl_rd,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  intv_rd,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  cnt_rd,
    output logic [WORD_W-1:0]              bus_rdata
);

    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    mtmr_sub_e        sub;

    assign blk = bus_addr[ADDR_W-1:4];
    assign sub = mtmr_sub_e'(bus_addr[3:2]);

    always_comb begin
        wr_ien    = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
        wr_stat   = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
        wr_ctrl   = '0;
        wr_intv   = '0;
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_IEN))  bus_rdata = WORD_W'(ien_q);
        if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = WORD_W'(stat_q);
        for (int n = 0; n < NUM_CH; n++) begin
            if (blk == BLK_W'(n + 1) && bus_addr[1:0] == 2'b00) begin
                unique case (sub)
                    SUB_CTRL: begin
                        bus_rdata  = ctrl_rd[n];
                        wr_ctrl[n] = bus_we;
                    end
                    SUB_INTV: begin
                        bus_rdata  = intv_rd[n];
                        wr_intv[n] = bus_we;
                    end
                    SUB_CNT:  bus_rdata = cnt_rd[n];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    // R2
    always_comb begin
        if (!rst) begin
            decode_onehot_chk: assert ($onehot0({wr_ien, wr_stat, wr_ctrl, wr_intv}));
        end
    end

endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel
    import mtmr_pkg::*;
#(
    parameter int STOP_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         ext_tick,
    input  logic               wr_ctrl,
    input  logic               wr_intv,
    input  logic [WORD_W-1:0]  wdata,
    output mtmr_ctrl_t         ctrl_q,
    output logic [WORD_W-1:0]  intv_q,
    output logic [WORD_W-1:0]  cnt_q,
    output logic               expire
);

    localparam int STOP_W = $clog2(STOP_TICKS + 1);

    mtmr_ctrl_t          wctrl;
    logic                run;
    logic [STOP_W-1:0]   stop_left;
    logic [PDIV_W-1:0]   prediv;
    logic [NUM_SRC-1:0]  src_vec;
    logic                src_hit;
    logic [PDIV_W-1:0]   mask;
    logic                tick;

    assign wctrl   = mtmr_ctrl_t'(wdata[7:0]);
    assign src_vec = {ext_tick, 1'b1};
    assign src_hit = src_vec[ctrl_q.src];
    assign mask    = pre_mask(ctrl_q.pre);
    assign tick    = run && src_hit && ((prediv & mask) == mask);
    assign expire  = tick && !ctrl_q.rld && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            intv_q    <= '0;
            cnt_q     <= '0;
            run       <= 1'b0;
            stop_left <= '0;
            prediv    <= '0;
        end else begin
            if (!run) stop_left <= '0;
            if (run && src_hit) prediv <= prediv + 1'b1;

            if (tick) begin
                if (stop_left != '0) begin
                    stop_left <= stop_left - 1'b1;
                    if (stop_left == STOP_W'(1)) run <= 1'b0;
                end
                if (ctrl_q.rld) begin
                    cnt_q      <= intv_q;
                    ctrl_q.rld <= 1'b0;
                end else if (cnt_q == '0) begin
                    if (ctrl_q.one) begin
                        run       <= 1'b0;
                        ctrl_q.en <= 1'b0;
                        stop_left <= '0;
                    end else begin
                        cnt_q <= intv_q;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            if (wr_intv) intv_q <= wdata;

            if (wr_ctrl) begin
                ctrl_q <= wctrl;
                if (wctrl.en) begin
                    run       <= 1'b1;
                    stop_left <= '0;
                    if (!run) prediv <= '0;
                end else if (run && stop_left == '0) begin
                    stop_left <= STOP_W'(STOP_TICKS);
                end
            end
        end
    end

    // R11
    stop_limit_chk: assert property (@(posedge clk) disable iff (rst)
        stop_left <= STOP_W'(STOP_TICKS));

    // R11
    halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q));

    // R6
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.one && !wr_ctrl) |=> (!run && !ctrl_q.en && cnt_q == '0));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl_q.rld && !wr_ctrl && !wr_intv) |=> (cnt_q == intv_q && !ctrl_q.rld));

    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctrl_q.one && !wr_intv) |=> (cnt_q == intv_q));

endmodule

// File: rtl/mtmr_irq.sv
module mtmr_irq
    import mtmr_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ien,
    input  logic               wr_stat,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [NUM_CH-1:0]  expire,
    output logic [NUM_CH-1:0]  ien_q,
    output logic [NUM_CH-1:0]  stat_q,
    output logic               irq_o
);

    logic [NUM_CH-1:0] clr;

    assign clr   = wr_stat ? wdata[NUM_CH-1:0] : '0;
    assign irq_o = |(stat_q & ien_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            stat_q <= '0;
        end else begin
            if (wr_ien) ien_q <= wdata[NUM_CH-1:0];
            stat_q <= (stat_q & ~clr) | expire;
        end
    end

    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && expire == '0) |=> (stat_q == ($past(stat_q) & ~$past(wdata[NUM_CH-1:0]))));

    // R10
    expiry_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|expire) |=> ((stat_q & $past(expire)) == $past(expire)));

endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int ADDR_W     = 8,
    parameter int STOP_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [2:0]         ext_tick,
    output logic               irq_o
);

    logic                          wr_ien, wr_stat;
    logic [NUM_CH-1:0]             wr_ctrl, wr_intv, expire, ien_q, stat_q;
    logic [NUM_CH-1:0][WORD_W-1:0] ctrl_rd, intv_rd, cnt_rd;

    mtmr_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regif_i (
        .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .wr_ien(wr_ien), .wr_stat(wr_stat), .wr_ctrl(wr_ctrl), .wr_intv(wr_intv),
        .ien_q(ien_q), .stat_q(stat_q),
        .ctrl_rd(ctrl_rd), .intv_rd(intv_rd), .cnt_rd(cnt_rd),
        .bus_rdata(bus_rdata)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        mtmr_ctrl_t c_q;
        mtmr_channel #(.STOP_TICKS(STOP_TICKS)) ch_i (
            .clk(clk), .rst(rst), .ext_tick(ext_tick),
            .wr_ctrl(wr_ctrl[n]), .wr_intv(wr_intv[n]), .wdata(bus_wdata),
            .ctrl_q(c_q), .intv_q(intv_rd[n]), .cnt_q(cnt_rd[n]),
            .expire(expire[n])
        );
        assign ctrl_rd[n] = ctrl_word(c_q);
    end

    mtmr_irq #(.NUM_CH(NUM_CH)) irq_i (
        .clk(clk), .rst(rst), .wr_ien(wr_ien), .wr_stat(wr_stat),
        .wdata(bus_wdata), .expire(expire),
        .ien_q(ien_q), .stat_q(stat_q), .irq_o(irq_o)
    );

endmodule

// File: tb/mtmr_top_tb_top.sv
module mtmr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  ext_tick = '0;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] rv, rv2;

    always #5 clk = ~clk;

    mtmr_top dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_tick(ext_tick), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_tick[0] = 1'b1;
            @(negedge clk); ext_tick[0] = 1'b0;
        end
    endtask

    task automatic t_reset();
        for (int a = 0; a < 12; a++) begin
            rd(8'(a * 4), rv);
            check("R1 reset register", rv, 32'h0);
        end
        check("R1 reset irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_map();
        wr(8'h24, 32'h12345678);
        rd(8'h24, rv); check("R2 ch1 interval", rv, 32'h12345678);
        wr(8'h28, 32'hDEADBEEF);
        rd(8'h28, rv); check("R2 count ignores write", rv, 32'h0);
        rd(8'h0C, rv); check("R2 unmapped", rv, 32'h0);
        wr(8'h24, 32'h0);
    endtask

    task automatic t_load_periodic();
        wr(8'h14, 32'd5);
        wr(8'h10, 32'h07);
        rd(8'h10, rv); check("R3 ctrl readback", rv, 32'h07);
        repeat (4) @(negedge clk);
        rd(8'h18, rv); check("R7 no tick without strobe", rv, 32'h0);
        pulse(1);
        rd(8'h18, rv); check("R4 load tick", rv, 32'd5);
        rd(8'h10, rv); check("R3 reload self-clears", rv, 32'h05);
        pulse(2);
        rd(8'h18, rv); check("R4 decrement", rv, 32'd3);
        pulse(3);
        rd(8'h18, rv); check("R5 at zero", rv, 32'd0);
        rd(8'h04, rv); check("R5 no status yet", rv, 32'h0);
        pulse(1);
        rd(8'h18, rv); check("R5 reload", rv, 32'd5);
        rd(8'h04, rv); check("R10 status without enable", rv, 32'h1);
        check("R10 irq masked", 32'(irq_o), 32'h0);
        wr(8'h00, 32'h1);
        #1 check("R10 irq raised", 32'(irq_o), 32'h1);
        wr(8'h04, 32'h0);
        rd(8'h04, rv); check("R9 write 0 keeps", rv, 32'h1);
        wr(8'h04, 32'h1);
        rd(8'h04, rv); check("R9 write 1 clears", rv, 32'h0);
        check("R10 irq dropped", 32'(irq_o), 32'h0);
    endtask

    task automatic t_oneshot();
        wr(8'h14, 32'd2);
        wr(8'h10, 32'h87);
        pulse(1);
        rd(8'h18, rv); check("R6 load", rv, 32'd2);
        pulse(2);
        rd(8'h18, rv); check("R6 at zero", rv, 32'd0);
        pulse(1);
        rd(8'h04, rv); check("R6 status", rv, 32'h1);
        rd(8'h10, rv); check("R6 enable cleared", rv, 32'h84);
        pulse(3);
        rd(8'h18, rv); check("R6 stays zero", rv, 32'd0);
        wr(8'h04, 32'h1);
    endtask

    task automatic t_prescale_disable();
        wr(8'h14, 32'd10);
        wr(8'h10, 32'h27);
        pulse(3);
        rd(8'h18, rv); check("R8 not yet ticked", rv, 32'd0);
        pulse(1);
        rd(8'h18, rv); check("R8 fourth strobe", rv, 32'd10);
        pulse(3);
        rd(8'h18, rv); check("R8 partial", rv, 32'd10);
        pulse(1);
        rd(8'h18, rv); check("R8 second tick", rv, 32'd9);
        wr(8'h10, 32'h05);
        pulse(1);
        rd(8'h18, rv); check("R13 resume", rv, 32'd8);
        wr(8'h10, 32'h04);
        rd(8'h10, rv); check("R11 enable reads 0", rv, 32'h04);
        pulse(1);
        rd(8'h18, rv); check("R11 first late tick", rv, 32'd7);
        pulse(1);
        rd(8'h18, rv); check("R11 second late tick", rv, 32'd6);
        pulse(3);
        rd(8'h18, rv); check("R11 frozen", rv, 32'd6);
    endtask

    task automatic t_wrap();
        wr(8'h14, 32'd1);
        wr(8'h10, 32'h07);
        pulse(1);
        rd(8'h18, rv); check("R12 loaded", rv, 32'd1);
        wr(8'h14, 32'hFFFFFFFF);
        pulse(2);
        rd(8'h18, rv); check("R12 wrap", rv, 32'hFFFFFFFF);
        pulse(1);
        rd(8'h18, rv); check("R12 keeps running", rv, 32'hFFFFFFFE);
        wr(8'h10, 32'h04);
        pulse(4);
        wr(8'h04, 32'h3);
    endtask

    task automatic t_core_clock();
        wr(8'h24, 32'hFFFFFFFF);
        wr(8'h20, 32'h03);
        repeat (3) @(negedge clk);
        rd(8'h28, rv);
        repeat (2) @(negedge clk);
        rd(8'h28, rv2);
        check("R7 core clock tick rate", rv - rv2, 32'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_load_periodic();
        t_oneshot();
        t_prescale_disable();
        t_wrap();
        t_core_clock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule